// File: doc/BRIEF.md
# Host Packet-Memory Access Port

This block sits between a host register bus and a byte-addressed packet SRAM. It keeps a read pointer and a write pointer, and it turns host register commands into SRAM traffic. A peek returns the bytes at the read pointer and leaves the pointer where it is. A stepping read returns the same kind of data and then moves the pointer on by the host bus width. A store command writes the host word at the write pointer and leaves that pointer unchanged. A host word holds one, two or four bytes, packed little-endian from consecutive byte addresses.

Read data comes from a small prefetch buffer. Loading either byte of the read pointer, and every peek or stepping read, empties the buffer and refills it from the SRAM at the current pointer. While a refill or a store is in progress the `busy` output is high, and every host command is dropped. The read pointer wraps in one of two ways, chosen by `rx_mode`. With `rx_mode` at 0 the limit is a fixed boundary. With `rx_mode` at 1 the limit is a programmable receive-region size. Reset loads the region size with a default just under 8 KiB.

Top module: `hsp_port`

## Requirements
- R1: While `rst_n` is low, `busy` is high. After reset the read pointer and write pointer are 0, the region size register holds 16'h1F00, and `busy` falls once the first buffer fill completes.
- R2: Command code 0 writes and reads back read-pointer bits [7:0], and code 1 does the same for bits [15:8]. A write to either code raises `busy` in the next cycle while the buffer refills.
- R3: A peek read (code 4) returns the bytes at the read pointer and leaves the pointer unchanged. Repeated peeks return the same data.
- R4: A stepping read (code 5) returns the bytes at the read pointer and then advances the pointer by 1, 2 or 4 when `bus_mode` is 0, 1 or 2 (3 behaves like 2).
- R5: Read data is little-endian: byte n of the word, at bits [8n+7:8n], comes from pointer+n. Bits above the active width read as zero.
- R6: With `rx_mode`=0, a pointer step that reaches 16384 returns the pointer to 0.
- R7: Codes 2 and 3 write and read back region-size bits [7:0] and [15:8]. With `rx_mode`=1, a pointer step that reaches the region size returns the pointer to 0.
- R8: The wrap test uses the pointer after the step. A multi-byte step that passes the limit lands on 0, not on the overshoot.
- R9: Codes 7 and 8 write and read back write-pointer bits [7:0] and [15:8]. A store (code 6) writes the low 1, 2 or 4 bytes of `cmd_wdata` little-endian at the write pointer, one byte per cycle, and leaves the write pointer unchanged.
- R10: A command offered while `busy` is high is ignored. No pointer changes and no `cmd_rvalid` follows.
- R11: Buffer bytes whose address pointer+n reaches the limit are fetched from address pointer+n minus the limit.
- R12: An accepted register read drives `cmd_rvalid` high for exactly the next cycle, with the result on `cmd_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Host width: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| rx_mode | input | 1 | 0: wrap at the fixed boundary; 1: wrap at the region size |
| cmd_addr | input | 4 | Command/register code |
| cmd_wr | input | 1 | Write strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data, valid with cmd_rvalid |
| cmd_rvalid | output | 1 | Read result valid |
| busy | output | 1 | Fill or store in progress; commands are dropped |
| mem_addr | output | 16 | SRAM byte address |
| mem_re | output | 1 | SRAM read enable (data returns next cycle) |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 8 | SRAM write byte |
| mem_rdata | input | 8 | SRAM read byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 32-bit host bus, a fixed boundary of 16384 and a region-size default of 16'h1F00. That one build covers the reset default and all three host widths. The fixed boundary is reached by loading the pointer just below 16384 instead of stepping through memory. The region-size wrap and the overshoot case are reached by programming a 64-byte region through the size registers. In that small region, both 2-byte and 4-byte steps hit the limit exactly or pass it, and a fill straddles the end of the region.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

   localparam logic [3:0] C_RPTR_LO = 4'd0;
   localparam logic [3:0] C_RPTR_HI = 4'd1;
   localparam logic [3:0] C_RXSZ_LO = 4'd2;
   localparam logic [3:0] C_RXSZ_HI = 4'd3;
   localparam logic [3:0] C_PEEK    = 4'd4;
   localparam logic [3:0] C_RD_STEP = 4'd5;
   localparam logic [3:0] C_STORE   = 4'd6;
   localparam logic [3:0] C_WPTR_LO = 4'd7;
   localparam logic [3:0] C_WPTR_HI = 4'd8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_STORE = 2'd2
   } seq_st_e;

   // bytes per host word for a bus_mode code
   function automatic logic [2:0] step_of(input logic [1:0] m);
      case (m)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/hsp_wrap.sv
// Adds a small offset to a base address and folds the sum at a limit.
// TO_ZERO=1: a sum at or past the limit becomes zero (pointer stepping).
// TO_ZERO=0: a sum at or past the limit has the limit subtracted (fill lanes).
module hsp_wrap #(
   parameter int AW      = 16,
   parameter int OW      = 3,
   parameter bit TO_ZERO = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [OW-1:0] ofs,
   input  logic [AW:0]   limit,
   output logic [AW-1:0] addr
);
   logic [AW:0] sum;
   assign sum = {1'b0, base} + {{(AW+1-OW){1'b0}}, ofs};

   generate
      if (TO_ZERO) begin : g_zero
         assign addr = (sum >= limit) ? '0 : sum[AW-1:0];
      end else begin : g_mod
         assign addr = (sum >= limit) ? (sum[AW-1:0] - limit[AW-1:0]) : sum[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/hsp_prefetch.sv
module hsp_prefetch #(
   parameter int NB = 4,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set_valid,
   input  logic          cap_en,
   input  logic [CW-1:0] cap_idx,
   input  logic [7:0]    cap_byte,
   input  logic [CW-1:0] lanes,
   output logic [NB*8-1:0] word,
   output logic          valid
);
   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (cap_en && cap_idx == CW'(i))    q <= cap_byte;
         end
         assign word[i*8 +: 8] = (CW'(i) < lanes) ? q : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid <= 1'b0;
      else if (clr)       valid <= 1'b0;
      else if (set_valid) valid <= 1'b1;
   end

   // R5: captured bytes always land in an existing lane
   p_cap_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> (cap_idx < CW'(NB)));
endmodule

// File: rtl/hsp_seq.sv
module hsp_seq #(
   parameter int NB = 4,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_fill,
   input  logic          start_store,
   input  logic [CW-1:0] store_n,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          mem_re,
   output logic          mem_we,
   output logic          cap_en,
   output logic [CW-1:0] cap_idx,
   output logic          fill_done
);
   import hsp_pkg::*;

   seq_st_e       st;
   logic [CW-1:0] cnt_q, n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_FILL;
         cnt_q <= '0;
         n_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cnt_q <= '0;
               if (start_fill)       st <= ST_FILL;
               else if (start_store) begin
                  st  <= ST_STORE;
                  n_q <= store_n;
               end
            end
            ST_FILL: begin
               if (cnt_q == CW'(NB)) begin
                  st    <= ST_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            ST_STORE: begin
               if (cnt_q == n_q - CW'(1)) begin
                  st    <= ST_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (st != ST_IDLE);
      cnt       = cnt_q;
      mem_re    = (st == ST_FILL) && (cnt_q < CW'(NB));
      cap_en    = (st == ST_FILL) && (cnt_q != '0);
      cap_idx   = cnt_q - CW'(1);
      mem_we    = (st == ST_STORE);
      fill_done = (st == ST_FILL) && (cnt_q == CW'(NB));
   end

   // R9: a store never writes more bytes than requested
   p_store_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STORE) |-> (cnt_q < n_q));
   // R3: the fill ends and the port is released right after the last byte
   p_fill_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !busy);
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
   parameter int          AW       = 16,
   parameter int          HOST_W   = 32,
   parameter int          FIX_WRAP = 16384,
   parameter logic [15:0] RXSZ_RST = 16'h1F00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_mode,
   input  logic              rx_mode,
   input  logic [3:0]        cmd_addr,
   input  logic              cmd_wr,
   input  logic              cmd_rd,
   input  logic [HOST_W-1:0] cmd_wdata,
   output logic [HOST_W-1:0] cmd_rdata,
   output logic              cmd_rvalid,
   output logic              busy,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   import hsp_pkg::*;

   localparam int NB = HOST_W / 8;
   localparam int CW = $clog2(NB + 1);

   generate
      if (!(HOST_W == 8 || HOST_W == 16 || HOST_W == 32)) begin : g_bad_host
         $error("hsp_port: HOST_W must be 8, 16 or 32");
      end
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("hsp_port: AW must be 9..16");
      end
      if (FIX_WRAP < 1 || FIX_WRAP > (1 << AW)) begin : g_bad_wrap
         $error("hsp_port: FIX_WRAP out of address range");
      end
   endgenerate

   logic [AW-1:0]     rptr, wptr, rxsz, next_rptr;
   logic [AW:0]       limit;
   logic [2:0]        raw_step;
   logic [CW-1:0]     lanes;
   logic              acc_wr, acc_rd, start_fill, start_store;
   logic [HOST_W-1:0] store_q, rd_mux, buf_word;
   logic              buf_valid;
   logic [NB*AW-1:0]  fill_addr;
   logic [CW-1:0]     seq_cnt, cap_idx;
   logic              cap_en, fill_done, re_i, we_i;

   always_comb begin
      raw_step = step_of(bus_mode);
      lanes    = (raw_step > 3'(NB)) ? CW'(NB) : CW'(raw_step);
      limit    = rx_mode ? {1'b0, rxsz} : (AW+1)'(FIX_WRAP);
   end

   assign acc_wr = cmd_wr && !busy;
   assign acc_rd = cmd_rd && !cmd_wr && !busy;

   assign start_fill  = (acc_wr && (cmd_addr == C_RPTR_LO || cmd_addr == C_RPTR_HI)) ||
                        (acc_rd && (cmd_addr == C_PEEK || cmd_addr == C_RD_STEP));
   assign start_store = acc_wr && (cmd_addr == C_STORE);

   // pointer after a stepping read
   hsp_wrap #(.AW(AW), .OW(CW), .TO_ZERO(1'b1)) u_adv (
      .base (rptr),
      .ofs  (lanes),
      .limit(limit),
      .addr (next_rptr)
   );

   // one folded byte address per buffer lane
   generate
      for (genvar i = 0; i < NB; i++) begin : g_fill
         hsp_wrap #(.AW(AW), .OW(CW), .TO_ZERO(1'b0)) u_lane (
            .base (rptr),
            .ofs  (CW'(i)),
            .limit(limit),
            .addr (fill_addr[i*AW +: AW])
         );
      end
   endgenerate

   hsp_seq #(.NB(NB), .CW(CW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_fill (start_fill),
      .start_store(start_store),
      .store_n    (lanes),
      .busy       (busy),
      .cnt        (seq_cnt),
      .mem_re     (re_i),
      .mem_we     (we_i),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .fill_done  (fill_done)
   );

   hsp_prefetch #(.NB(NB), .CW(CW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start_fill),
      .set_valid(fill_done),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_byte (mem_rdata),
      .lanes    (lanes),
      .word     (buf_word),
      .valid    (buf_valid)
   );

   // SRAM port steering
   always_comb begin
      mem_addr  = wptr + AW'(seq_cnt);
      mem_wdata = store_q[7:0];
      for (int i = 0; i < NB; i++) begin
         if (seq_cnt == CW'(i)) begin
            if (re_i) mem_addr = fill_addr[i*AW +: AW];
            mem_wdata = store_q[i*8 +: 8];
         end
      end
      mem_re = re_i;
      mem_we = we_i;
   end

   always_comb begin
      case (cmd_addr)
         C_RPTR_LO: rd_mux = HOST_W'(rptr[7:0]);
         C_RPTR_HI: rd_mux = HOST_W'(rptr[AW-1:8]);
         C_RXSZ_LO: rd_mux = HOST_W'(rxsz[7:0]);
         C_RXSZ_HI: rd_mux = HOST_W'(rxsz[AW-1:8]);
         C_WPTR_LO: rd_mux = HOST_W'(wptr[7:0]);
         C_WPTR_HI: rd_mux = HOST_W'(wptr[AW-1:8]);
         C_PEEK,
         C_RD_STEP: rd_mux = buf_word;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr       <= '0;
         wptr       <= '0;
         rxsz       <= RXSZ_RST[AW-1:0];
         store_q    <= '0;
         cmd_rdata  <= '0;
         cmd_rvalid <= 1'b0;
      end else begin
         cmd_rvalid <= acc_rd;
         if (acc_rd) cmd_rdata <= rd_mux;
         if (acc_rd && cmd_addr == C_RD_STEP) rptr <= next_rptr;
         if (acc_wr) begin
            case (cmd_addr)
               C_RPTR_LO: rptr[7:0]    <= cmd_wdata[7:0];
               C_RPTR_HI: rptr[AW-1:8] <= cmd_wdata[AW-9:0];
               C_RXSZ_LO: rxsz[7:0]    <= cmd_wdata[7:0];
               C_RXSZ_HI: rxsz[AW-1:8] <= cmd_wdata[AW-9:0];
               C_WPTR_LO: wptr[7:0]    <= cmd_wdata[7:0];
               C_WPTR_HI: wptr[AW-1:8] <= cmd_wdata[AW-9:0];
               C_STORE:   store_q      <= cmd_wdata;
               default:   ;
            endcase
         end
      end
   end

   // R3: a peek leaves the read pointer in place
   p_peek_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && cmd_addr == C_PEEK) |=> (rptr == $past(rptr)));
   // R3: read data is only offered from a filled buffer
   p_idle_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> buf_valid);
   // R4: a step that stays inside the limit adds exactly the width
   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && cmd_addr == C_RD_STEP && (({1'b0, rptr} + (AW+1)'(lanes)) < limit))
      |=> (rptr == $past(rptr) + AW'($past(lanes))));
   // R8: after a step the pointer is always inside the limit
   p_in_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && cmd_addr == C_RD_STEP) |=> ({1'b0, rptr} < $past(limit)));
   // R9: a store leaves the write pointer in place
   p_wptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_store |=> (wptr == $past(wptr)));
   // R10: commands offered while busy change nothing
   p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cmd_wr || cmd_rd)) |=> ($stable(rptr) && $stable(wptr) && $stable(rxsz) && !cmd_rvalid));
   // R12: one-cycle read response
   p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> cmd_rvalid);
   p_rvalid_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> !cmd_rvalid);
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
   localparam logic [3:0] K_RPLO = 4'd0, K_RPHI = 4'd1, K_SZLO = 4'd2, K_SZHI = 4'd3,
                          K_PEEK = 4'd4, K_STEP = 4'd5, K_STOR = 4'd6,
                          K_WPLO = 4'd7, K_WPHI = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_mode = 2'd2;
   logic        rx_mode = 1'b0;
   logic [3:0]  cmd_addr = '0;
   logic        cmd_wr = 1'b0, cmd_rd = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        cmd_rvalid, busy;
   logic [15:0] mem_addr;
   logic        mem_re, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hsp_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .rx_mode(rx_mode),
      .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .cmd_rvalid(cmd_rvalid), .busy(busy),
      .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // SRAM model: computed pattern overlaid by a small write log
   logic [15:0] wl_a [16];
   logic [7:0]  wl_d [16];
   int          wl_n = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'(((a & 255) * 7 + ((a >> 8) & 255) * 13 + 5) & 255);
   endfunction

   function automatic logic [7:0] mem_byte(input int a);
      for (int i = wl_n - 1; i >= 0; i--)
         if (int'(wl_a[i]) == a) return wl_d[i];
      return pat(a);
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem_byte(int'(mem_addr));
      if (mem_we && wl_n < 16) begin
         wl_a[wl_n] <= mem_addr;
         wl_d[wl_n] <= mem_wdata;
         wl_n       <= wl_n + 1;
      end
   end

   function automatic logic [31:0] exp_word(input int ptr, input int nb, input int lim);
      logic [31:0] w = '0;
      for (int i = 0; i < nb; i++) begin
         int a = ptr + i;
         if (a >= lim) a = a - lim;
         w[i*8 +: 8] = mem_byte(a);
      end
      return w;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 200) begin
         @(negedge clk);
         t++;
      end
      if (t >= 200) check("R10 busy stuck", 32'(busy), 32'd0);
   endtask

   task automatic wr_raw(input logic [3:0] a, input logic [31:0] d);
      cmd_addr = a; cmd_wdata = d; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      wait_idle();
      wr_raw(a, d);
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      wait_idle();
      cmd_addr = a; cmd_rd = 1'b1;
      @(negedge clk);
      cmd_rd = 1'b0;
      check("R12 rvalid after read", 32'(cmd_rvalid), 32'd1);
      d = cmd_rdata;
   endtask

   task automatic set_rptr(input int v);
      reg_wr(K_RPLO, 32'(v & 255));
      reg_wr(K_RPHI, 32'((v >> 8) & 255));
   endtask

   task automatic get_rptr(output int v);
      logic [31:0] lo, hi;
      reg_rd(K_RPLO, lo);
      reg_rd(K_RPHI, hi);
      v = int'({hi[7:0], lo[7:0]});
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 busy during reset fill", 32'(busy), 32'd1);
      wait_idle();
      reg_rd(K_RPLO, d); check("R1 rptr lo", d, 32'h0);
      reg_rd(K_RPHI, d); check("R1 rptr hi", d, 32'h0);
      reg_rd(K_WPLO, d); check("R1 wptr lo", d, 32'h0);
      reg_rd(K_WPHI, d); check("R1 wptr hi", d, 32'h0);
      reg_rd(K_SZLO, d); check("R1 rxsize lo", d, 32'h00);
      reg_rd(K_SZHI, d); check("R1 rxsize hi", d, 32'h1F);
   endtask

   task automatic t_ptr_regs();
      logic [31:0] d;
      rx_mode = 1'b0; bus_mode = 2'd2;
      reg_wr(K_RPLO, 32'h34);
      check("R2 busy after pointer load", 32'(busy), 32'd1);
      reg_wr(K_RPHI, 32'h12);
      reg_rd(K_RPLO, d); check("R2 rptr lo readback", d, 32'h34);
      reg_rd(K_RPHI, d); check("R2 rptr hi readback", d, 32'h12);
   endtask

   task automatic t_peek();
      logic [31:0] d; int p;
      bus_mode = 2'd2; set_rptr(16'h1234);
      reg_rd(K_PEEK, d); check("R3 peek 32-bit", d, exp_word(16'h1234, 4, 16384));
      reg_rd(K_PEEK, d); check("R3 second peek same", d, exp_word(16'h1234, 4, 16384));
      get_rptr(p); check("R3 pointer unchanged", 32'(p), 32'h1234);
      bus_mode = 2'd0;
      reg_rd(K_PEEK, d); check("R5 8-bit upper zero", d, exp_word(16'h1234, 1, 16384));
      bus_mode = 2'd1;
      reg_rd(K_PEEK, d); check("R5 16-bit little-endian", d, exp_word(16'h1234, 2, 16384));
   endtask

   task automatic t_step();
      logic [31:0] d; int p;
      rx_mode = 1'b0;
      bus_mode = 2'd1; set_rptr(16'h1234);
      reg_rd(K_STEP, d); check("R4 16-bit data", d, exp_word(16'h1234, 2, 16384));
      get_rptr(p); check("R4 step 2", 32'(p), 32'h1236);
      bus_mode = 2'd2;
      reg_rd(K_STEP, d); check("R4 32-bit data", d, exp_word(16'h1236, 4, 16384));
      get_rptr(p); check("R4 step 4", 32'(p), 32'h123A);
      bus_mode = 2'd0;
      reg_rd(K_STEP, d); check("R4 8-bit data", d, exp_word(16'h123A, 1, 16384));
      get_rptr(p); check("R4 step 1", 32'(p), 32'h123B);
      bus_mode = 2'd3;
      reg_rd(K_STEP, d); check("R4 mode 3 data", d, exp_word(16'h123B, 4, 16384));
      get_rptr(p); check("R4 mode 3 steps 4", 32'(p), 32'h123F);
   endtask

   task automatic t_wrap_fixed();
      logic [31:0] d; int p;
      rx_mode = 1'b0;
      bus_mode = 2'd0; set_rptr(16'h3FFF);
      reg_rd(K_STEP, d); check("R6 last byte", d, 32'(pat(16'h3FFF)));
      get_rptr(p); check("R6 wrap to zero", 32'(p), 32'h0);
      bus_mode = 2'd2; set_rptr(16'h3FFE);
      reg_rd(K_STEP, d);
      check("R11 fill straddles boundary", d,
            {pat(1), pat(0), pat(16'h3FFF), pat(16'h3FFE)});
      get_rptr(p); check("R8 overshoot lands on zero", 32'(p), 32'h0);
   endtask

   task automatic t_wrap_rx();
      logic [31:0] d; int p;
      reg_wr(K_SZLO, 32'h40);
      reg_wr(K_SZHI, 32'h00);
      reg_rd(K_SZLO, d); check("R7 rxsize lo readback", d, 32'h40);
      reg_rd(K_SZHI, d); check("R7 rxsize hi readback", d, 32'h00);
      rx_mode = 1'b1;
      bus_mode = 2'd1; set_rptr(16'h003E);
      reg_rd(K_STEP, d); check("R7 data at region end", d, exp_word(16'h3E, 2, 16'h40));
      get_rptr(p); check("R7 wrap at region size", 32'(p), 32'h0);
      bus_mode = 2'd2; set_rptr(16'h003F);
      reg_rd(K_STEP, d);
      check("R11 region fill folds", d, {pat(2), pat(1), pat(0), pat(16'h3F)});
      get_rptr(p); check("R8 region overshoot to zero", 32'(p), 32'h0);
      bus_mode = 2'd0; set_rptr(16'h0010);
      reg_rd(K_STEP, d);
      get_rptr(p); check("R7 step inside region", 32'(p), 32'h11);
      rx_mode = 1'b0;
   endtask

   task automatic t_store();
      logic [31:0] d;
      rx_mode = 1'b0; bus_mode = 2'd2;
      reg_wr(K_WPLO, 32'h10);
      reg_wr(K_WPHI, 32'h20);
      reg_wr(K_STOR, 32'hA1B2C3D4);
      reg_rd(K_WPLO, d); check("R9 wptr lo unchanged", d, 32'h10);
      reg_rd(K_WPHI, d); check("R9 wptr hi unchanged", d, 32'h20);
      set_rptr(16'h2010);
      reg_rd(K_PEEK, d); check("R9 32-bit store readback", d, 32'hA1B2C3D4);
      reg_wr(K_WPLO, 32'h20);
      bus_mode = 2'd1;
      reg_wr(K_STOR, 32'hEEEE5566);
      bus_mode = 2'd2; set_rptr(16'h2020);
      reg_rd(K_PEEK, d);
      check("R9 16-bit store two bytes only", d, {pat(16'h2023), pat(16'h2022), 8'h55, 8'h66});
   endtask

   task automatic t_busy();
      logic [31:0] d;
      rx_mode = 1'b0; bus_mode = 2'd2;
      reg_wr(K_RPHI, 32'h05);
      reg_wr(K_RPLO, 32'h50);
      check("R10 busy after load", 32'(busy), 32'd1);
      wr_raw(K_RPLO, 32'h77);
      cmd_addr = K_STEP; cmd_rd = 1'b1;
      @(negedge clk);
      cmd_rd = 1'b0;
      check("R10 no response while busy", 32'(cmd_rvalid), 32'd0);
      reg_rd(K_RPLO, d); check("R10 rptr lo kept", d, 32'h50);
      reg_rd(K_RPHI, d); check("R10 rptr hi kept", d, 32'h05);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ptr_regs();
      t_peek();
      t_step();
      t_wrap_fixed();
      t_wrap_rx();
      t_store();
      t_busy();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule